// File: doc/BRIEF.md
# Bypassable Half-Rate Decimation Cascade

This block reduces the sample rate of a complex receive stream by a power of two between 1 and 32. It is a fixed chain of five half-rate stages. Each stage can be switched in or out. A switched-in stage low-pass filters the stream with a short symmetric half-band filter and keeps one sample out of every two. A switched-out stage forwards every sample after one register. The overall ratio is therefore two raised to the number of stages that are switched in.

Signed 16-bit I and Q samples arrive with a valid strobe, and the strobe may drop for any number of cycles. The chain produces 16-bit I and Q samples with their own valid strobe. Software programs a stage-select word. That word takes effect only when a synchronous flush is pulsed, and the flush also empties every delay line. Samples filtered under one ratio are therefore never mixed with samples filtered under another.

Top module: `dec_cascade`

## Requirements
- R1: After reset `out_valid` is low, all delay lines hold zero, and the active stage-select word is all ones (ratio 32) until the first flush.
- R2: Bit k of the active stage-select word switches in stage k, where stage 0 is nearest the input. The chain emits exactly floor(N / 2^m) samples for N accepted inputs since the last flush, where m is the number of set bits.
- R3: A switched-in stage emits an output on the 2nd, 4th, 6th... sample it accepts after a flush. The output is (acc + 16) >>> 5, where acc = -x0 + 9*x2 + 16*x3 + 9*x4 - x6 and x0 is the newest accepted sample. A constant input settles to exactly the same constant (unity DC gain).
- R4: Stage results outside [-32768, 32767] are clamped to the nearer limit.
- R5: A switched-out stage forwards each sample unchanged with one cycle of latency. With every stage switched out, an input accepted at clock edge E appears on the outputs after edge E+4.
- R6: Changes on `cfg_mask` have no effect until `flush` is high at a clock edge. At that edge the active word is loaded from `cfg_mask`.
- R7: A flush clears all delay lines, phase counters and pending outputs. `out_valid` is low in the cycle after a flush, and a sample presented in the flush cycle is discarded.
- R8: Stages advance only on accepted samples. Idle cycles change neither the values nor the count of the outputs. Once `in_valid` has been low for more than five edges, `out_valid` stays low.
- R9: The I and Q streams are filtered independently with identical arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous flush; loads the stage-select word |
| cfg_mask | input | 5 | Requested stage-select word, bit k for stage k |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input I sample, signed |
| in_q | input | 16 | Input Q sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Output I sample, signed |
| out_q | output | 16 | Output Q sample, signed |

## Verification
The bench compares every output against a sample-by-sample model of the cascade. It uses the reset ratio, sparse and dense stage-select words, and inputs with idle gaps, so a stage that keeps the wrong phase, advances on idle cycles or applies the wrong taps shows up as a mismatch in count or value. An alternating full-scale pattern drives both I and Q past their limits, which exposes a design that wraps instead of clamping. Further tests change the select word without a flush, present a sample during a flush, and flush while a stage is half way to an output; a design that applies the new word early, keeps the discarded sample or carries stale phase across the flush gives the wrong count. An all-bypass test measures the exact latency.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int SW     = 16;
    localparam int NTAP   = 7;
    localparam int CSHIFT = 5;
    localparam int ACCW   = SW + CSHIFT + 3;
    localparam int RND    = 1 << (CSHIFT - 1);
    localparam int SMAX   = (1 << (SW - 1)) - 1;
    localparam int SMIN   = -(1 << (SW - 1));

    typedef logic signed [SW-1:0] smp_t;
    typedef logic [NTAP-1:0][SW-1:0] line_t;

    // Half-band taps, scaled by 2**CSHIFT; index 0 is the newest sample.
    function automatic int hb_coef(input int k);
        case (k)
            3:       return 16;
            2, 4:    return 9;
            0, 6:    return -1;
            default: return 0;
        endcase
    endfunction

    function automatic smp_t hb_apply(input line_t w);
        logic signed [ACCW-1:0] acc;
        logic signed [ACCW-1:0] sh;
        acc = '0;
        for (int k = 0; k < NTAP; k++) begin
            acc = acc + ACCW'(hb_coef(k)) * ACCW'($signed(w[k]));
        end
        sh = (acc + ACCW'(RND)) >>> CSHIFT;
        if (sh > ACCW'(SMAX))      return smp_t'(SMAX);
        else if (sh < ACCW'(SMIN)) return smp_t'(SMIN);
        else                       return smp_t'(sh);
    endfunction
endpackage

// File: rtl/dec_mask_reg.sv
module dec_mask_reg #(
    parameter int NSTAGE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [NSTAGE-1:0] cfg_mask,
    output logic [NSTAGE-1:0] act_mask
);
    logic [NSTAGE-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (flush) mask_d = cfg_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

    assign act_mask = mask_q;
endmodule

// File: rtl/dec_hb_stage.sv
module dec_hb_stage import dec_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic stage_on,
    input  logic in_valid,
    input  smp_t in_i,
    input  smp_t in_q,
    output logic out_valid,
    output smp_t out_i,
    output smp_t out_q
);
    typedef struct packed {
        line_t line_i;
        line_t line_q;
        logic  phase;
        smp_t  oi;
        smp_t  oq;
        logic  ov;
    } st_t;

    st_t   st_d, st_q;
    line_t nl_i, nl_q;

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        nl_i    = {st_q.line_i[NTAP-2:0], in_i};
        nl_q    = {st_q.line_q[NTAP-2:0], in_q};
        if (flush) begin
            st_d = '0;
        end else if (in_valid) begin
            if (!stage_on) begin
                st_d.oi = in_i;
                st_d.oq = in_q;
                st_d.ov = 1'b1;
            end else begin
                st_d.line_i = nl_i;
                st_d.line_q = nl_q;
                st_d.phase  = ~st_q.phase;
                if (st_q.phase) begin
                    st_d.oi = hb_apply(nl_i);
                    st_d.oq = hb_apply(nl_q);
                    st_d.ov = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_i     = st_q.oi;
    assign out_q     = st_q.oq;
endmodule

// File: rtl/dec_cascade.sv
module dec_cascade import dec_pkg::*; #(
    parameter int NSTAGE = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [NSTAGE-1:0]    cfg_mask,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_i,
    input  logic signed [SW-1:0] in_q,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_i,
    output logic signed [SW-1:0] out_q
);
    logic [NSTAGE-1:0] act_mask;
    logic [NSTAGE:0]   vld;
    smp_t              si [NSTAGE+1];
    smp_t              sq [NSTAGE+1];

    dec_mask_reg #(.NSTAGE(NSTAGE)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .cfg_mask (cfg_mask),
        .act_mask (act_mask)
    );

    assign vld[0] = in_valid;
    assign si[0]  = in_i;
    assign sq[0]  = in_q;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        dec_hb_stage u_st (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .stage_on  (act_mask[g]),
            .in_valid  (vld[g]),
            .in_i      (si[g]),
            .in_q      (sq[g]),
            .out_valid (vld[g+1]),
            .out_i     (si[g+1]),
            .out_q     (sq[g+1])
        );
    end

    assign out_valid = vld[NSTAGE];
    assign out_i     = si[NSTAGE];
    assign out_q     = sq[NSTAGE];
endmodule

// File: rtl/dec_cascade_chk.sv
module dec_cascade_chk #(
    parameter int NSTAGE = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic [NSTAGE-1:0] cfg_mask,
    input logic              in_valid,
    input logic              out_valid
);
    logic [NSTAGE-1:0] mask_q;
    logic [NSTAGE-1:0] pipe_q;
    logic [31:0]       in_cnt, out_cnt;
    logic [7:0]        idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '1;
            pipe_q  <= '0;
            in_cnt  <= '0;
            out_cnt <= '0;
            idle_q  <= '0;
        end else begin
            if (in_valid && !flush)  idle_q <= '0;
            else if (idle_q != 8'hFF) idle_q <= idle_q + 8'd1;
            if (flush) begin
                mask_q  <= cfg_mask;
                pipe_q  <= '0;
                in_cnt  <= '0;
                out_cnt <= '0;
            end else begin
                pipe_q <= {pipe_q[NSTAGE-2:0], in_valid};
                if (in_valid)  in_cnt  <= in_cnt + 32'd1;
                if (out_valid) out_cnt <= out_cnt + 32'd1;
            end
        end
    end

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R7

    AST_RATE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((out_cnt + 32'd1) << $countones(mask_q)) <= in_cnt)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(idle_q) > NSTAGE) |-> !out_valid); // R8

    AST_BYPASS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (out_valid == pipe_q[NSTAGE-1])); // R5
endmodule

bind dec_cascade dec_cascade_chk #(.NSTAGE(NSTAGE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .cfg_mask  (cfg_mask),
    .in_valid  (in_valid),
    .out_valid (out_valid)
);

// File: tb/sim_dec_cascade.sv
`timescale 1ns/1ps
module sim_dec_cascade;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               flush = 1'b0;
    logic [4:0]         cfg_mask = 5'b11111;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;

    int src_i[$], src_q[$], exp_i[$], exp_q[$], got_i[$], got_q[$];
    int n_chk = 0;
    int n_err = 0;
    int seed  = 32'h1234_5678;

    always #2 clk = ~clk;

    dec_cascade u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_mask(cfg_mask),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got_i.push_back(int'(out_i));
            got_q.push_back(int'(out_q));
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int prng();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 12) % 24000;
    endfunction

    function automatic int hb_ref(input int w[7]);
        int acc, y;
        acc = -w[0] + 9 * w[2] + 16 * w[3] + 9 * w[4] - w[6];
        y = (acc + 16) >>> 5;
        if (y > 32767)  y = 32767;
        if (y < -32768) y = -32768;
        return y;
    endfunction

    task automatic model_path(input int x[$], input logic [4:0] m, output int y[$]);
        int cur[$];
        int nxt[$];
        int w[7];
        bit ph;
        cur = x;
        for (int s = 0; s < 5; s++) begin
            if (m[s]) begin
                nxt = {};
                for (int k = 0; k < 7; k++) w[k] = 0;
                ph = 1'b0;
                foreach (cur[n]) begin
                    for (int k = 6; k > 0; k--) w[k] = w[k-1];
                    w[0] = cur[n];
                    if (ph) nxt.push_back(hb_ref(w));
                    ph = ~ph;
                end
                cur = nxt;
            end
        end
        y = cur;
    endtask

    task automatic do_flush(input logic [4:0] m, input bit junk);
        @(posedge clk); #1;
        cfg_mask = m;
        flush    = 1'b1;
        in_valid = junk;
        in_i     = 16'sd5000;
        in_q     = -16'sd5000;
        @(posedge clk); #1;
        flush    = 1'b0;
        in_valid = 1'b0;
        got_i = {};
        got_q = {};
    endtask

    task automatic drive(input int gap);
        foreach (src_i[n]) begin
            in_valid = 1'b1;
            in_i = 16'(src_i[n]);
            in_q = 16'(src_q[n]);
            @(posedge clk); #1;
            in_valid = 1'b0;
            if (gap > 0) repeat (n % gap) begin @(posedge clk); #1; end
        end
        repeat (20) begin @(posedge clk); #1; end
    endtask

    task automatic compare(input string req, input logic [4:0] m);
        int bad, fa, fe;
        model_path(src_i, m, exp_i);
        model_path(src_q, m, exp_q);
        chk(got_i.size() == exp_i.size(), {req, " count"}, got_i.size(), exp_i.size());
        bad = 0; fa = 0; fe = 0;
        if (got_i.size() == exp_i.size()) begin
            foreach (exp_i[n]) begin
                if (got_i[n] != exp_i[n] || got_q[n] != exp_q[n]) begin
                    if (bad == 0) begin
                        fa = (got_i[n] != exp_i[n]) ? got_i[n] : got_q[n];
                        fe = (got_i[n] != exp_i[n]) ? exp_i[n] : exp_q[n];
                    end
                    bad++;
                end
            end
        end
        chk(bad == 0, {req, " values"}, fa, fe);
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        src_i = {}; src_q = {};
        for (int n = 0; n < 64; n++) begin src_i.push_back(500); src_q.push_back(-700); end
        got_i = {}; got_q = {};
        drive(0);
        chk(got_i.size() == 2, "R1 reset ratio is 32", got_i.size(), 2);
        compare("R1", 5'b11111);
    endtask

    task automatic t_dc();
        do_flush(5'b11111, 1'b0);
        src_i = {}; src_q = {};
        for (int n = 0; n < 640; n++) begin src_i.push_back(1000); src_q.push_back(-2000); end
        drive(0);
        chk(got_i.size() == 20, "R2 ratio 32 count", got_i.size(), 20);
        if (got_i.size() > 0) begin
            chk(got_i[$] == 1000, "R3 DC unity gain I", got_i[$], 1000);
            chk(got_q[$] == -2000, "R3 DC unity gain Q", got_q[$], -2000);
        end
    endtask

    task automatic t_ratio8();
        do_flush(5'b10101, 1'b0);
        src_i = {}; src_q = {};
        for (int n = 0; n < 256; n++) begin src_i.push_back(prng()); src_q.push_back(prng()); end
        drive(0);
        chk(got_i.size() == 32, "R2 ratio 8 count", got_i.size(), 32);
        compare("R3 R9 ratio 8", 5'b10101);
    endtask

    task automatic t_gaps();
        do_flush(5'b01010, 1'b0);
        src_i = {}; src_q = {};
        for (int n = 0; n < 202; n++) begin src_i.push_back(prng()); src_q.push_back(-prng()); end
        drive(4);
        chk(got_i.size() == 50, "R8 count with gaps", got_i.size(), 50);
        compare("R8 gaps", 5'b01010);
    endtask

    task automatic t_bypass();
        int lat;
        do_flush(5'b00000, 1'b0);
        in_valid = 1'b1; in_i = 16'sd1234; in_q = -16'sd77;
        @(posedge clk); #1;
        in_valid = 1'b0;
        lat = 0;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            if (out_valid && lat == 0) lat = n;
        end
        chk(lat == 5, "R5 bypass latency", lat, 5);
        chk(got_i.size() == 1 && got_i[0] == 1234 && got_q[0] == -77,
            "R5 bypass value", (got_i.size() > 0) ? got_i[0] : -1, 1234);
    endtask

    task automatic t_nochange();
        do_flush(5'b11111, 1'b0);
        cfg_mask = 5'b00001;
        src_i = {}; src_q = {};
        for (int n = 0; n < 96; n++) begin src_i.push_back(300); src_q.push_back(300); end
        drive(0);
        chk(got_i.size() == 3, "R6 mask ignored without flush", got_i.size(), 3);
        do_flush(5'b00001, 1'b0);
        src_i = {}; src_q = {};
        for (int n = 0; n < 8; n++) begin src_i.push_back(300); src_q.push_back(300); end
        drive(0);
        chk(got_i.size() == 4, "R6 mask applied at flush", got_i.size(), 4);
    endtask

    task automatic t_sat();
        int mx, mn;
        do_flush(5'b00001, 1'b0);
        src_i = {0}; src_q = {0};
        for (int n = 0; n < 48; n++) begin
            src_i.push_back((n % 6 == 0) ? -32768 : 32767);
            src_q.push_back((n % 6 == 0) ? 32767 : -32768);
        end
        drive(0);
        compare("R4 saturation", 5'b00001);
        mx = -100000; mn = 100000;
        foreach (got_i[n]) if (got_i[n] > mx) mx = got_i[n];
        foreach (got_q[n]) if (got_q[n] < mn) mn = got_q[n];
        chk(mx == 32767, "R4 upper clamp", mx, 32767);
        chk(mn == -32768, "R4 lower clamp", mn, -32768);
    endtask

    task automatic t_flush();
        do_flush(5'b00001, 1'b0);
        src_i = {7000}; src_q = {7000};
        drive(0);
        do_flush(5'b00001, 1'b1);
        src_i = {100}; src_q = {-100};
        drive(0);
        chk(got_i.size() == 0, "R7 phase cleared by flush", got_i.size(), 0);
        src_i = {300}; src_q = {-300};
        drive(0);
        src_i = {100, 300}; src_q = {-100, -300};
        compare("R7 lines cleared and flush sample dropped", 5'b00001);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_dc();
        t_ratio8();
        t_gaps();
        t_bypass();
        t_nochange();
        t_sat();
        t_flush();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule